// File: doc/BRIEF.md
# Reloadable Transposed FIR Filter

This block is a fully parallel finite impulse response filter built in transposed form. Every accepted input sample is multiplied by all tap coefficients at once, and the products are folded into a chain of registered partial sums. The result is one filtered output for each input sample, with one cycle of latency. Each tap has its own general-purpose multiplier, because both of its operands can change.

The coefficients are held in a shift-register chain. A new set is loaded serially through a dedicated port, one word per clock, while filtering is paused. After a reload the partial sums still hold terms computed with the old coefficients. For that reason the output-valid flag stays low until those terms have drained from the chain.

Top module: `tfir_reload`

## Requirements
- R1: After reset, `out_vld` is 0, `out_dat` is 0, all coefficients are 0 and the sample history counts as zeros. The first accepted sample after reset already yields a valid output of 0.
- R2: With coefficients h[0..TAPS-1] loaded, an isolated unit sample (value 1) produces outputs h[0], h[1], ..., h[TAPS-1] on successive accepted samples.
- R3: Load order: the first word presented on `cf_in` ends up as h[TAPS-1], the tap furthest from the output. The last word (the TAPS-th) becomes h[0].
- R4: A sample is accepted when `smp_vld` is 1 and `cf_ld` is 0. In the next cycle `out_vld` is 1 and `out_dat` equals the sum over k of h[k]*x[n-k], where x[n] is the newest accepted sample. Samples and coefficients are signed two's complement.
- R5: Cycles with `smp_vld` low do not advance the filter. The output sequence depends only on the accepted samples, not on the gaps between them.
- R6: While `cf_ld` is 1, each cycle shifts one coefficient in, `smp_vld` and `smp_in` are ignored, and `out_vld` is 0 in the following cycle.
- R7: After a reload, the outputs for the first TAPS-1 accepted samples have `out_vld` at 0. The output for the TAPS-th accepted sample is valid and uses only post-reload samples.
- R8: `out_dat` is full precision: DW+CW+clog2(TAPS) bits, signed. It does not overflow even with all operands at -2^15.
- R9: `out_dat` changes only in the cycle after an accepted sample. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Input sample qualifier |
| smp_in | input | DW | Signed input sample |
| cf_ld | input | 1 | Coefficient shift enable; pauses filtering |
| cf_in | input | CW | Signed coefficient word shifted in while `cf_ld` is 1 |
| out_vld | output | 1 | Output qualifier, one per accepted sample outside the flush window |
| out_dat | output | DW+CW+clog2(TAPS) | Signed full-precision filter output |

## Verification
A unit impulse after a reload reads the coefficient set back in tap order. It shows whether the load direction and the transposed coefficient reversal line up, and whether the flush window is exactly TAPS-1 samples long. A pseudo-random stream, checked against a convolution model, separates correct signed arithmetic from errors in the partial-sum wiring. The same stream broken up by idle cycles shows that only accepted samples advance the chain. A reload with junk samples present, and a run with all operands at the most negative value, expose samples leaking in during a load and lost guard bits.

// File: rtl/tfir_reload.sv
module tfir_reload #(
  parameter int TAPS = 80,
  parameter int DW   = 16,
  parameter int CW   = 16,
  localparam int AW  = DW + CW + $clog2(TAPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp_in,
  input  logic          cf_ld,
  input  logic [CW-1:0] cf_in,
  output logic          out_vld,
  output logic [AW-1:0] out_dat
);
  localparam int PW = DW + CW;
  localparam int FW = $clog2(TAPS + 1);

  logic signed [CW-1:0] cf   [TAPS];
  logic signed [AW-1:0] ps   [TAPS];
  logic signed [AW-1:0] nxt  [TAPS];
  logic signed [PW-1:0] prod [TAPS];
  logic [FW-1:0]        fill;
  logic signed [PW-1:0] xs;

  wire take = smp_vld & ~cf_ld;
  assign xs = PW'($signed(smp_in));
  assign out_dat = ps[0];

  always_comb begin
    for (int j = 0; j < TAPS; j++)
      prod[j] = xs * PW'(cf[j]);
    for (int j = 0; j < TAPS - 1; j++)
      nxt[j] = AW'(prod[j]) + ps[j+1];
    nxt[TAPS-1] = AW'(prod[TAPS-1]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < TAPS; j++) begin
        cf[j] <= '0;
        ps[j] <= '0;
      end
      fill    <= '0;
      out_vld <= 1'b0;
    end else begin
      if (cf_ld) begin
        cf[0] <= $signed(cf_in);
        for (int j = 1; j < TAPS; j++)
          cf[j] <= cf[j-1];
        fill <= FW'(TAPS - 1);
      end else if (take && fill != '0) begin
        fill <= fill - 1'b1;
      end
      if (take)
        for (int j = 0; j < TAPS; j++)
          ps[j] <= nxt[j];
      out_vld <= take && (fill == '0);
    end
  end
endmodule

module tfir_reload_chk #(
  parameter int TAPS = 80,
  parameter int AW   = 39
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_vld,
  input logic          cf_ld,
  input logic          out_vld,
  input logic [AW-1:0] out_dat
);
  a_r6_quiet_during_load: assert property (@(posedge clk) disable iff (!rst_n)
    cf_ld |=> !out_vld);

  a_r4_valid_follows_sample: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(smp_vld && !cf_ld));

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_vld && !cf_ld) |=> $stable(out_dat));

  a_r5_no_valid_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> !out_vld);

  if (TAPS > 1) begin : g_flush
    a_r7_first_after_load_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      (cf_ld ##1 (smp_vld && !cf_ld)) |=> !out_vld);
  end
endmodule

bind tfir_reload tfir_reload_chk #(.TAPS(TAPS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .cf_ld(cf_ld),
  .out_vld(out_vld), .out_dat(out_dat));

// File: tb/tfir_reload_tb.sv
module tfir_reload_tb;
  localparam int N  = 8;
  localparam int AW = 16 + 16 + $clog2(N);

  logic clk = 0, rst_n = 0, smp_vld = 0, cf_ld = 0;
  logic [15:0] smp_in = '0, cf_in = '0;
  logic out_vld;
  logic [AW-1:0] out_dat;

  int checks = 0, errors = 0;
  longint hm [N];
  longint hist [N];
  int mfill = 0;
  logic [15:0] lf = 16'hACE1;
  bit done = 0;

  tfir_reload #(.TAPS(N), .DW(16), .CW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_in(smp_in),
    .cf_ld(cf_ld), .cf_in(cf_in), .out_vld(out_vld), .out_dat(out_dat));

  always #5 clk = ~clk;

  function automatic longint sdat();
    return longint'($signed(out_dat));
  endfunction

  function automatic logic [15:0] rnd();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(string tag, logic [15:0] x);
    longint acc = 0;
    bit ev;
    @(negedge clk);
    smp_vld = 1; smp_in = x;
    @(posedge clk); #1;
    for (int k = N - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = longint'($signed(x));
    ev = (mfill == 0);
    if (mfill != 0) mfill--;
    for (int k = 0; k < N; k++) acc += hm[k] * hist[k];
    check({tag, " out_vld"}, longint'(out_vld), longint'(ev));
    if (ev) check({tag, " out_dat"}, sdat(), acc);
  endtask

  task automatic idle(int n);
    longint held;
    held = sdat();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_vld = 0; smp_in = rnd();
      @(posedge clk); #1;
      check("R5 idle out_vld", longint'(out_vld), 0);
      check("R9 idle hold", sdat(), held);
    end
  endtask

  task automatic load(longint h [N], bit junk);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      cf_ld = 1; cf_in = 16'(h[N-1-i]);
      smp_vld = junk; smp_in = rnd();
      @(posedge clk); #1;
      check("R6 load out_vld", longint'(out_vld), 0);
    end
    @(negedge clk);
    cf_ld = 0; smp_vld = 0;
    for (int k = 0; k < N; k++) hm[k] = h[k];
    mfill = N - 1;
  endtask

  task automatic t_reset();
    check("R1 reset out_vld", longint'(out_vld), 0);
    check("R1 reset out_dat", sdat(), 0);
    send("R1 first sample", 16'd1234);
  endtask

  task automatic t_impulse();
    longint h [N];
    for (int k = 0; k < N; k++) h[k] = 100 * (k + 1) - 3 * k * k;
    h[N-1] = -777;
    load(h, 0);
    for (int i = 0; i < N - 1; i++) send("R7 flush", 16'd0);
    send("R2 impulse h0", 16'd1);
    check("R3 last word is h0", sdat(), h[0]);
    for (int k = 1; k < N; k++) send("R2 impulse tail", 16'd0);
    check("R3 first word is hN-1", sdat(), h[N-1]);
  endtask

  task automatic t_stream();
    for (int i = 0; i < 40; i++) send("R4 stream", rnd());
  endtask

  task automatic t_stall();
    for (int i = 0; i < 12; i++) begin
      send("R5 gapped", rnd());
      idle(i % 3 + 1);
    end
  endtask

  task automatic t_junk_reload();
    longint h [N];
    for (int k = 0; k < N; k++) h[k] = longint'($signed(rnd()));
    load(h, 1);
    for (int i = 0; i < N + 10; i++) send("R6 after junk reload", rnd());
  endtask

  task automatic t_extreme();
    longint h [N];
    for (int k = 0; k < N; k++) h[k] = -32768;
    load(h, 0);
    for (int i = 0; i < N; i++) send("R8 max positive", 16'h8000);
    check("R8 full value", sdat(), longint'(N) * 1073741824);
    for (int k = 0; k < N; k++) h[k] = 32767;
    load(h, 0);
    for (int i = 0; i < N; i++) send("R8 max negative", 16'h8000);
    check("R8 full neg", sdat(), -longint'(N) * 32767 * 32768);
  endtask

  initial begin
    for (int k = 0; k < N; k++) begin hm[k] = 0; hist[k] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    t_reset();
    t_impulse();
    t_stream();
    t_stall();
    t_junk_reload();
    t_extreme();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule